// File: doc/BRIEF.md
# Memory Self-Test Data Pattern Generator and Checker

This block produces the data side of a memory built-in self-test. After a start request it emits a programmed number of 32-bit words on a write strobe. The words follow one of six data patterns, and each pattern is aimed at a different class of fault:

- a rising count, for address and duplicate-word faults;
- a pseudo-random stream;
- a single set bit and a single clear bit that walk across the word, for bridged or stuck data lines;
- an all-ones/all-zeros toggle, for worst-case simultaneous switching;
- an alternating-bit toggle, for crosstalk between neighbours.

The memory path around the block stores the words and later returns them on the read side with a valid strobe. A second, independent copy of the generator replays the same sequence and compares each returned word against it.

Mismatches are counted in a saturating error counter. The first mismatch is captured with its word index, the expected value and the actual value, and the capture is held until the next start. A one-cycle done pulse marks the moment the last expected word has been compared. Address generation, the memory controller and any margining stay outside the block.

Top module: `mbist_patgen`

## Requirements
- R1: With mode code 0 (incrementing), write word i equals i as a 32-bit value (0, 1, 2, 3, ...).
- R2: With mode code 1 (pseudo-random), a 31-bit shift register is loaded with 31'h2BADF00D at every accepted start. Each step computes bit b = s[30] XOR s[27], then shifts to s = {s[29:0], b}. Each word is formed from 32 consecutive values of b, with the first step's bit placed at bit 31. Every pass therefore repeats the same sequence.
- R3: With mode code 2 (walking one), write word i has only bit (i mod 32) set, so it wraps from bit 31 back to bit 0.
- R4: With mode code 3 (walking zero), write word i has only bit (i mod 32) clear, so it wraps from bit 31 back to bit 0.
- R5: With mode code 4 (full toggle), even-index words are 32'hFFFFFFFF and odd-index words are 32'h00000000.
- R6: With mode code 5 (checkerboard), even-index words are 32'h55555555 and odd-index words are 32'hAAAAAAAA.
- R7: The mode and word count are sampled only when a start is accepted. Mode codes 6 and 7 behave as incrementing. A change on the mode input during a pass has no effect on that pass.
- R8: After a start with a nonzero count is accepted, wr_valid is high for exactly word_count consecutive cycles, beginning in the cycle after the accepting clock edge. busy is high from that cycle until done.
- R9: While busy, each rd_valid cycle compares rd_data against the regenerated word whose index equals the number of reads already taken. Each mismatch increments err_count, which saturates at its all-ones value. An accepted start clears err_count to 0.
- R10: On the first mismatch of a pass, fail_seen goes high and fail_index, fail_expected and fail_actual capture that read's index, expected word and returned word. Later mismatches do not change the capture. An accepted start clears fail_seen.
- R11: done is high for exactly one cycle, in the cycle after the clock edge that takes the word_count-th read. busy is low in that same cycle.
- R12: A start with word_count 0 produces no write strobe and raises done in the following cycle. It still clears the error count and the failure capture.
- R13: start is ignored while busy. rd_valid is ignored while not busy, so err_count and the failure capture stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| mode | input | 3 | Pattern code, sampled at start |
| word_count | input | CNT_W | Number of words in the pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_data | output | 32 | Generated write word |
| wr_valid | output | 1 | wr_data is valid this cycle |
| rd_data | input | 32 | Returned read word |
| rd_valid | input | 1 | rd_data is valid this cycle |
| err_count | output | ERR_W | Saturating mismatch count |
| fail_seen | output | 1 | A mismatch has been captured |
| fail_index | output | CNT_W | Read index of the first mismatch |
| fail_expected | output | 32 | Expected word at the first mismatch |
| fail_actual | output | 32 | Returned word at the first mismatch |

## Verification
A writer generator stepping wrongly shows up on wr_data within one word of the fault. The same is true of a pattern decode error, since each write is compared word by word against an independently computed sequence. A checker generator that drifts from the writer shows up as a nonzero err_count, and a wrong first-failure capture appears on the fail outputs, on the clean loopback that follows each pass. Counter faults in the control path appear as a wrong number of write strobes or a done pulse one cycle early or late. Saturation, a reserved mode, a start while busy, a read while idle and a zero count are each driven on purpose, and the ports are read right after.

// File: rtl/mbist_pat_pkg.sv
`timescale 1ns/1ps
package mbist_pat_pkg;

    localparam int WORD_W = 32;
    localparam int LFSR_W = 31;
    localparam int TAP_HI = 30;
    localparam int TAP_LO = 27;
    localparam logic [LFSR_W-1:0] PRBS_SEED = 31'h2BAD_F00D;

    typedef enum logic [2:0] {
        PAT_INCR    = 3'd0,
        PAT_PRBS    = 3'd1,
        PAT_WALK1   = 3'd2,
        PAT_WALK0   = 3'd3,
        PAT_FLIP    = 3'd4,
        PAT_CHECKER = 3'd5
    } pat_mode_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_WRITE = 2'd1,
        CTL_READ  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] idx;
        logic [LFSR_W-1:0] lfsr;
    } gen_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LFSR_W-1:0] next;
    } prbs_step_t;

    // Run the shift register one step per output bit, collecting a full word.
    function automatic prbs_step_t prbs_run(input logic [LFSR_W-1:0] s);
        prbs_step_t r;
        logic [LFSR_W-1:0] st;
        logic fb;
        st     = s;
        r.word = '0;
        for (int k = 0; k < WORD_W; k++) begin
            fb     = st[TAP_HI] ^ st[TAP_LO];
            r.word = {r.word[WORD_W-2:0], fb};
            st     = {st[LFSR_W-2:0], fb};
        end
        r.next = st;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pat_word(input logic [2:0] mode,
                                                   input gen_state_t gs);
        logic [WORD_W-1:0] one_hot;
        prbs_step_t ps;
        one_hot = {{(WORD_W-1){1'b0}}, 1'b1} << gs.idx[$clog2(WORD_W)-1:0];
        ps      = prbs_run(gs.lfsr);
        case (mode)
            PAT_PRBS:    pat_word = ps.word;
            PAT_WALK1:   pat_word = one_hot;
            PAT_WALK0:   pat_word = ~one_hot;
            PAT_FLIP:    pat_word = gs.idx[0] ? {WORD_W{1'b0}} : {WORD_W{1'b1}};
            PAT_CHECKER: pat_word = gs.idx[0] ? {(WORD_W/2){2'b10}} : {(WORD_W/2){2'b01}};
            default:     pat_word = gs.idx;
        endcase
    endfunction

endpackage

// File: rtl/mbist_pat_gen.sv
`timescale 1ns/1ps
module mbist_pat_gen
    import mbist_pat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [2:0]        mode,
    output logic [WORD_W-1:0] word
);
    gen_state_t gs;
    prbs_step_t nxt;

    always_comb nxt = prbs_run(gs.lfsr);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            gs.idx  <= '0;
            gs.lfsr <= PRBS_SEED;
        end else if (adv) begin
            gs.idx  <= gs.idx + 1'b1;
            gs.lfsr <= nxt.next;
        end
    end

    always_comb word = pat_word(mode, gs);
endmodule

// File: rtl/mbist_seq_ctrl.sv
`timescale 1ns/1ps
module mbist_seq_ctrl
    import mbist_pat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             rd_valid,
    output logic             load,
    output logic [2:0]       mode_q,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic [CNT_W-1:0] rd_idx,
    output logic             busy,
    output logic             done
);
    ctl_state_e       state;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        load     = start && (state == CTL_IDLE);
        wr_fire  = (state == CTL_WRITE);
        rd_fire  = rd_valid && (state != CTL_IDLE);
        busy     = (state != CTL_IDLE);
        rd_idx   = rd_cnt;
        last_idx = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CTL_IDLE;
            done    <= 1'b0;
            mode_q  <= '0;
            count_q <= '0;
            wr_cnt  <= '0;
            rd_cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                mode_q  <= mode_in;
                count_q <= count_in;
                wr_cnt  <= '0;
                rd_cnt  <= '0;
                if (count_in == '0) begin
                    done <= 1'b1;
                end else begin
                    state <= CTL_WRITE;
                end
            end else begin
                if (wr_fire) begin
                    wr_cnt <= wr_cnt + 1'b1;
                    if (wr_cnt == last_idx) begin
                        state <= CTL_READ;
                    end
                end
                if (rd_fire) begin
                    rd_cnt <= rd_cnt + 1'b1;
                    if (rd_cnt == last_idx) begin
                        state <= CTL_IDLE;
                        done  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mbist_cmp.sv
`timescale 1ns/1ps
module mbist_cmp
    import mbist_pat_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rd_fire,
    input  logic [CNT_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] expected,
    input  logic [WORD_W-1:0] actual,
    output logic [ERR_W-1:0]  err_count,
    output logic              fail_seen,
    output logic [CNT_W-1:0]  fail_index,
    output logic [WORD_W-1:0] fail_expected,
    output logic [WORD_W-1:0] fail_actual
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic miss;
    always_comb miss = rd_fire && (actual != expected);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_count     <= '0;
            fail_seen     <= 1'b0;
            fail_index    <= '0;
            fail_expected <= '0;
            fail_actual   <= '0;
        end else if (miss) begin
            if (err_count != ERR_MAX) begin
                err_count <= err_count + 1'b1;
            end
            if (!fail_seen) begin
                fail_seen     <= 1'b1;
                fail_index    <= rd_idx;
                fail_expected <= expected;
                fail_actual   <= actual;
            end
        end
    end
endmodule

// File: rtl/mbist_patgen.sv
`timescale 1ns/1ps
module mbist_patgen
    import mbist_pat_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [CNT_W-1:0]  word_count,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic [ERR_W-1:0]  err_count,
    output logic              fail_seen,
    output logic [CNT_W-1:0]  fail_index,
    output logic [WORD_W-1:0] fail_expected,
    output logic [WORD_W-1:0] fail_actual
);
    logic              load;
    logic [2:0]        mode_q;
    logic              wr_fire;
    logic              rd_fire;
    logic [CNT_W-1:0]  rd_idx;
    logic [WORD_W-1:0] exp_word;

    mbist_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_in  (mode),
        .count_in (word_count),
        .rd_valid (rd_valid),
        .load     (load),
        .mode_q   (mode_q),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .rd_idx   (rd_idx),
        .busy     (busy),
        .done     (done)
    );

    mbist_pat_gen u_wr_gen (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .adv  (wr_fire),
        .mode (mode_q),
        .word (wr_data)
    );

    mbist_pat_gen u_rd_gen (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .adv  (rd_fire),
        .mode (mode_q),
        .word (exp_word)
    );

    mbist_cmp #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_cmp (
        .clk           (clk),
        .rst           (rst),
        .clear         (load),
        .rd_fire       (rd_fire),
        .rd_idx        (rd_idx),
        .expected      (exp_word),
        .actual        (rd_data),
        .err_count     (err_count),
        .fail_seen     (fail_seen),
        .fail_index    (fail_index),
        .fail_expected (fail_expected),
        .fail_actual   (fail_actual)
    );

    always_comb wr_valid = wr_fire;
endmodule

// File: rtl/mbist_patgen_chk.sv
`timescale 1ns/1ps
module mbist_patgen_chk #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             wr_valid,
    input logic [ERR_W-1:0] err_count,
    input logic             fail_seen,
    input logic [CNT_W-1:0] fail_index,
    input logic [31:0]      fail_expected,
    input logic [31:0]      fail_actual
);
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r11_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r8_write_inside_pass: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    a_r9_count_never_drops: assert property (@(posedge clk) disable iff (rst)
        busy |=> (err_count >= $past(err_count)));

    a_r10_capture_held: assert property (@(posedge clk) disable iff (rst)
        (busy && fail_seen) |=> (fail_seen && $stable(fail_index)
                                 && $stable(fail_expected) && $stable(fail_actual)));

    a_r13_idle_read_inert: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err_count) && $stable(fail_seen)));
endmodule

bind mbist_patgen mbist_patgen_chk #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .wr_valid      (wr_valid),
    .err_count     (err_count),
    .fail_seen     (fail_seen),
    .fail_index    (fail_index),
    .fail_expected (fail_expected),
    .fail_actual   (fail_actual)
);

// File: tb/mbist_patgen_tb.sv
`timescale 1ns/1ps
module mbist_patgen_tb;
    localparam int CNT_W = 16;
    localparam int ERR_W = 4;
    localparam int MAXN  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [2:0]        mode = '0;
    logic [CNT_W-1:0]  word_count = '0;
    logic              busy, done, wr_valid, fail_seen;
    logic [31:0]       wr_data, fail_expected, fail_actual;
    logic [31:0]       rd_data = '0;
    logic              rd_valid = 1'b0;
    logic [ERR_W-1:0]  err_count;
    logic [CNT_W-1:0]  fail_index;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] expw [MAXN];
    logic [31:0] got  [MAXN];
    logic [31:0] cmask[MAXN];

    always #2 clk = ~clk;

    mbist_patgen #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .word_count(word_count),
        .busy(busy), .done(done), .wr_data(wr_data), .wr_valid(wr_valid),
        .rd_data(rd_data), .rd_valid(rd_valid), .err_count(err_count),
        .fail_seen(fail_seen), .fail_index(fail_index),
        .fail_expected(fail_expected), .fail_actual(fail_actual)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill_expected(input logic [2:0] m, input int n);
        logic [30:0] s;
        logic        b;
        logic [31:0] w;
        s = 31'h2BADF00D;
        for (int i = 0; i < n; i++) begin
            w = '0;
            for (int k = 0; k < 32; k++) begin
                b = s[30] ^ s[27];
                s = {s[29:0], b};
                w = {w[30:0], b};
            end
            case (m)
                3'd1: expw[i] = w;
                3'd2: expw[i] = 32'h1 << (i % 32);
                3'd3: expw[i] = ~(32'h1 << (i % 32));
                3'd4: expw[i] = (i % 2 == 0) ? 32'hFFFFFFFF : 32'h0;
                3'd5: expw[i] = (i % 2 == 0) ? 32'h55555555 : 32'hAAAAAAAA;
                default: expw[i] = i;
            endcase
        end
    endtask

    task automatic clear_masks();
        for (int i = 0; i < MAXN; i++) cmask[i] = '0;
    endtask

    // Start a pass, collect and check the writes, loop them back, check done.
    task automatic run_pass(input logic [2:0] m, input int n, input string tag,
                            input bit poke);
        int  wcnt;
        int  first_bad;
        bit  first_ok;
        fill_expected(m, n);
        @(negedge clk);
        mode = m; word_count = n[CNT_W-1:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_ok = wr_valid && busy;
        wcnt = 0;
        while (wr_valid && wcnt < MAXN) begin
            got[wcnt] = wr_data;
            wcnt++;
            if (poke && wcnt == 2) begin
                start = 1'b1; mode = m + 3'd1; word_count = 3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(first_ok, {tag, " R8 write strobe starts after start"}, 32'(first_ok), 32'd1);
        check(wcnt == n, {tag, " R8 write strobe count"}, wcnt, n);
        first_bad = -1;
        for (int i = 0; i < wcnt && i < n; i++)
            if (got[i] !== expw[i] && first_bad < 0) first_bad = i;
        if (first_bad >= 0)
            check(1'b0, {tag, " write data"}, got[first_bad], expw[first_bad]);
        else
            check(1'b1, {tag, " write data"}, 0, 0);
        for (int i = 0; i < n; i++) begin
            rd_valid = 1'b1;
            rd_data  = expw[i] ^ cmask[i];
            @(negedge clk);
            if (i < n - 1)
                check(!done && busy, {tag, " R11 no early done"}, 32'(done), 32'd0);
        end
        rd_valid = 1'b0;
        check(done && !busy, {tag, " R11 done after last read"}, 32'(done), 32'd1);
        @(negedge clk);
        check(!done, {tag, " R11 done lasts one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !wr_valid, "R8 idle after reset", {busy, done, wr_valid}, 0);
        check(err_count == 0 && !fail_seen, "R9 clear after reset", err_count, 0);
    endtask

    task automatic t_modes();
        clear_masks();
        run_pass(3'd0, 10, "R1 incrementing", 0);
        check(err_count == 0 && !fail_seen, "R9 clean incrementing readback", err_count, 0);
        run_pass(3'd1, 8, "R2 prbs pass A", 0);
        run_pass(3'd1, 8, "R2 prbs pass B reloads seed", 0);
        check(err_count == 0, "R2 clean prbs readback", err_count, 0);
        run_pass(3'd2, 34, "R3 walking one wrap", 0);
        run_pass(3'd3, 34, "R4 walking zero wrap", 0);
        run_pass(3'd4, 6, "R5 full toggle", 0);
        run_pass(3'd5, 6, "R6 checkerboard", 0);
        run_pass(3'd6, 5, "R7 reserved code 6", 0);
        run_pass(3'd7, 5, "R7 reserved code 7", 0);
        check(err_count == 0, "R9 clean reserved readback", err_count, 0);
    endtask

    task automatic t_errors();
        clear_masks();
        cmask[3] = 32'h0000_0010;
        cmask[7] = 32'h0000_FFFF;
        run_pass(3'd1, 12, "R9 prbs with corruption", 0);
        check(err_count == 2, "R9 two mismatches counted", err_count, 2);
        check(fail_seen, "R10 failure captured", 32'(fail_seen), 1);
        check(fail_index == 3, "R10 first index", fail_index, 3);
        check(fail_expected == expw[3], "R10 expected word", fail_expected, expw[3]);
        check(fail_actual == (expw[3] ^ 32'h10), "R10 actual word", fail_actual, expw[3] ^ 32'h10);
    endtask

    task automatic t_idle_read();
        for (int i = 0; i < 5; i++) begin
            rd_valid = 1'b1;
            rd_data  = 32'hDEAD_0000 + i;
            @(negedge clk);
        end
        rd_valid = 1'b0;
        @(negedge clk);
        check(err_count == 2, "R13 idle reads leave count", err_count, 2);
        check(fail_index == 3 && fail_actual == (expw[3] ^ 32'h10),
              "R13 idle reads leave capture", fail_index, 3);
    endtask

    task automatic t_saturate();
        clear_masks();
        for (int i = 0; i < 20; i++) cmask[i] = 32'h1;
        run_pass(3'd4, 20, "R9 all corrupt", 0);
        check(err_count == 4'hF, "R9 count saturates", err_count, 32'hF);
        check(fail_index == 0, "R10 first of many", fail_index, 0);
    endtask

    task automatic t_busy_start();
        clear_masks();
        run_pass(3'd2, 12, "R13 start while busy ignored", 1);
        check(err_count == 0, "R7 mode change mid-pass has no effect", err_count, 0);
    endtask

    task automatic t_zero();
        @(negedge clk);
        mode = 3'd0; word_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !busy && !wr_valid, "R12 zero count done next cycle", 32'(done), 1);
        check(err_count == 0 && !fail_seen, "R12 zero count clears record", err_count, 0);
        @(negedge clk);
        check(!done && !wr_valid, "R12 done single pulse", 32'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_modes();
        t_errors();
        t_idle_read();
        t_saturate();
        t_busy_start();
        t_errors();
        t_zero();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule